// File: doc/BRIEF.md
# Connection Memory Block Fill Controller

This block performs a one-shot bulk initialisation of two connection memories, one for the backplane side and one for the local side. Software first sets a global permission bit in a control register. It then writes a fill register that holds two 3-bit patterns and a start bit. Setting the start bit from low to high arms the fill. At the next frame boundary the block sweeps the full address range, writing one word per memory per clock. Each word carries its side's pattern in the top three bits, and the rest of the word is zero.

When the last address has been written, the start bit clears itself. Software reads that back as completion. Software can cancel a fill at any time by writing the start bit low or by dropping the global permission bit. Writes stop straight away, and locations already written keep their new contents. The patterns are captured when the fill is accepted. Later writes to the fill register therefore cannot disturb a fill in progress. The memory depth must not exceed the number of clocks in one frame.

Top module: `cm_block_fill`

## Requirements
- R1: After reset, both registers read 0, `busy` is low and neither write enable is high.
- R2: A fill-register write with bit 0 = 1 is accepted as a start only if the start bit currently reads 0, control bit 0 reads 1 and the block is idle. After that edge, `busy` is high and the start bit reads 1.
- R3: A fill-register write with bit 0 = 1 while control bit 0 is 0 is ignored. The start bit reads 0, `busy` stays low and no memory write occurs.
- R4: The sweep begins in the cycle after the first `frame_sync` sampled while armed. Both ports write in every sweep cycle, at the same address, ascending from 0 to DEPTH-1.
- R5: Each backplane word written is the backplane pattern in the top three bits with all lower bits zero.
- R6: Each local word written is the local pattern in the top three bits with all lower bits zero.
- R7: After the edge that writes address DEPTH-1, `busy` is low and the start bit reads 0.
- R8: A fill-register write with bit 0 = 0 while busy aborts. No memory write occurs after that edge, `busy` falls and the start bit reads 0. Locations already written keep their values.
- R9: A control-register write with bit 0 = 0 while busy aborts in the same way as R8. It also clears the start bit.
- R10: The patterns used by a sweep are those of the accepted start write. Fill-register writes while busy, including bit 0 = 1 with new patterns, change neither the patterns written nor the sweep timing.
- R11: Register layout. With `reg_sel` = 0 the control register is selected, and bit 0 is the global permission. With `reg_sel` = 1 the fill register is selected: bit 0 is start, bits 3:1 are the local pattern and bits 6:4 are the backplane pattern. All other bits read 0. Pattern fields read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 fill |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| frame_sync | input | 1 | One-cycle frame boundary pulse |
| busy | output | 1 | High from the accepted start until completion or abort |
| bp_we | output | 1 | Backplane memory write enable |
| bp_addr | output | log2(DEPTH) | Backplane memory address |
| bp_wdata | output | DATA_W | Backplane memory write data |
| lc_we | output | 1 | Local memory write enable |
| lc_addr | output | log2(DEPTH) | Local memory address |
| lc_wdata | output | DATA_W | Local memory write data |

## Verification
A wrong sweep state shows at the memory ports in the very cycle it arises. Examples are a missed frame boundary, a skipped or repeated address, or a stale pattern. The bench therefore compares every port with a behavioural model on every clock. An abort or completion that fails to clear the state shows one cycle later as `busy` or the start bit disagreeing with the model. It also appears as stray writes, which are counted over a following frame. Memory contents are captured from the ports and compared in full after each fill and each abort.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

    localparam int CMF_REG_W = 16;
    localparam int CMF_PAT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FILL  = 2'd2
    } cmf_state_e;

    typedef struct packed {
        logic                 allow;
        logic                 go;
        logic [CMF_PAT_W-1:0] bp_pat;
        logic [CMF_PAT_W-1:0] lc_pat;
    } cmf_regs_t;

endpackage

// File: rtl/cmf_regs.sv
module cmf_regs
    import cmf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [CMF_REG_W-1:0] reg_wdata,
    input  logic                 busy_i,
    input  logic                 done_i,
    output logic                 start_o,
    output logic                 abort_o,
    output logic [CMF_PAT_W-1:0] start_bp_pat_o,
    output logic [CMF_PAT_W-1:0] start_lc_pat_o,
    output logic [CMF_REG_W-1:0] reg_rdata
);
    localparam int GO_BIT = 0;
    localparam int LC_LSB = 1;
    localparam int BP_LSB = LC_LSB + CMF_PAT_W;
    localparam int TOP_USED = BP_LSB + CMF_PAT_W;

    cmf_regs_t regs_d, regs_q;
    logic      wr_fill, wr_ctrl;
    logic      unused_wbits;

    assign unused_wbits = ^reg_wdata[CMF_REG_W-1:TOP_USED];
    assign wr_fill = reg_wr && reg_sel;
    assign wr_ctrl = reg_wr && !reg_sel;

    assign start_bp_pat_o = reg_wdata[BP_LSB +: CMF_PAT_W];
    assign start_lc_pat_o = reg_wdata[LC_LSB +: CMF_PAT_W];

    always_comb begin
        regs_d  = regs_q;
        start_o = 1'b0;
        abort_o = 1'b0;
        if (done_i) begin
            regs_d.go = 1'b0;
        end
        if (wr_ctrl) begin
            regs_d.allow = reg_wdata[0];
            if (!reg_wdata[0]) begin
                regs_d.go = 1'b0;
                abort_o   = busy_i;
            end
        end
        if (wr_fill) begin
            regs_d.bp_pat = reg_wdata[BP_LSB +: CMF_PAT_W];
            regs_d.lc_pat = reg_wdata[LC_LSB +: CMF_PAT_W];
            if (!reg_wdata[GO_BIT]) begin
                regs_d.go = 1'b0;
                abort_o   = busy_i;
            end else if (!regs_q.go && regs_q.allow && !busy_i) begin
                regs_d.go = 1'b1;
                start_o   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[GO_BIT]                 = regs_q.go;
            reg_rdata[LC_LSB +: CMF_PAT_W]    = regs_q.lc_pat;
            reg_rdata[BP_LSB +: CMF_PAT_W]    = regs_q.bp_pat;
        end else begin
            reg_rdata[0] = regs_q.allow;
        end
    end

    // The start bit and the sweep engine's busy flag must agree on every cycle.
    assert_go_tracks_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.go == busy_i);

    // With permission low, an idle block stays idle.
    assert_locked_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.allow && !busy_i) |=> !busy_i);

    // An accepted abort leaves the block idle with the start bit clear.
    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (!regs_q.go && !busy_i));

endmodule

// File: rtl/cmf_sweep.sv
module cmf_sweep
    import cmf_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          abort_i,
    input  logic                          frame_sync,
    input  logic [CMF_PAT_W-1:0]          bp_pat_i,
    input  logic [CMF_PAT_W-1:0]          lc_pat_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          we_o,
    output logic [$clog2(DEPTH)-1:0]      addr_o,
    output logic [1:0][DATA_W-1:0]        wdata_o
);
    localparam int AW     = $clog2(DEPTH);
    localparam int ZERO_W = DATA_W - CMF_PAT_W;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        cmf_state_e                 st;
        logic [AW-1:0]              addr;
        logic [1:0][CMF_PAT_W-1:0]  pat;
    } sweep_t;

    sweep_t sw_d, sw_q;

    always_comb begin
        sw_d   = sw_q;
        done_o = 1'b0;
        unique case (sw_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    sw_d.st     = ST_ARMED;
                    sw_d.pat[0] = bp_pat_i;
                    sw_d.pat[1] = lc_pat_i;
                    sw_d.addr   = '0;
                end
            end
            ST_ARMED: begin
                if (frame_sync) begin
                    sw_d.st   = ST_FILL;
                    sw_d.addr = '0;
                end
            end
            ST_FILL: begin
                if (sw_q.addr == LAST) begin
                    sw_d.st = ST_IDLE;
                    done_o  = 1'b1;
                end else begin
                    sw_d.addr = sw_q.addr + 1'b1;
                end
            end
            default: sw_d.st = ST_IDLE;
        endcase
        if (abort_i) begin
            sw_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '{st: ST_IDLE, addr: '0, pat: '0};
        end else begin
            sw_q <= sw_d;
        end
    end

    assign busy_o = (sw_q.st != ST_IDLE);
    assign we_o   = (sw_q.st == ST_FILL);
    assign addr_o = sw_q.addr;

    for (genvar p = 0; p < 2; p++) begin : g_port
        assign wdata_o[p] = {sw_q.pat[p], {ZERO_W{1'b0}}};
    end

    // A sweep always enters at address 0, straight from the armed state.
    assert_fill_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q.st == ST_ARMED && frame_sync && !abort_i) |=> (sw_q.st == ST_FILL && sw_q.addr == '0));

    // Inside a sweep the address steps by one each clock.
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q.st == ST_FILL && sw_q.addr != LAST && !abort_i) |=> (sw_q.st == ST_FILL && sw_q.addr == $past(sw_q.addr) + 1'b1));

    // The last address ends the sweep.
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q.st == ST_FILL && sw_q.addr == LAST) |=> (sw_q.st == ST_IDLE));

    // Latched patterns hold for the whole operation.
    assert_pattern_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q.st != ST_IDLE && $past(sw_q.st) != ST_IDLE) |-> $stable(sw_q.pat));

endmodule

// File: rtl/cm_block_fill.sv
module cm_block_fill
    import cmf_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_sel,
    input  logic [CMF_REG_W-1:0]     reg_wdata,
    output logic [CMF_REG_W-1:0]     reg_rdata,
    input  logic                     frame_sync,
    output logic                     busy,
    output logic                     bp_we,
    output logic [$clog2(DEPTH)-1:0] bp_addr,
    output logic [DATA_W-1:0]        bp_wdata,
    output logic                     lc_we,
    output logic [$clog2(DEPTH)-1:0] lc_addr,
    output logic [DATA_W-1:0]        lc_wdata
);
    localparam int AW = $clog2(DEPTH);

    logic                   start, abort, done, we;
    logic [CMF_PAT_W-1:0]   st_bp_pat, st_lc_pat;
    logic [AW-1:0]          addr;
    logic [1:0][DATA_W-1:0] wdata;

    cmf_regs i_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_sel        (reg_sel),
        .reg_wdata      (reg_wdata),
        .busy_i         (busy),
        .done_i         (done),
        .start_o        (start),
        .abort_o        (abort),
        .start_bp_pat_o (st_bp_pat),
        .start_lc_pat_o (st_lc_pat),
        .reg_rdata      (reg_rdata)
    );

    cmf_sweep #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) i_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .abort_i    (abort),
        .frame_sync (frame_sync),
        .bp_pat_i   (st_bp_pat),
        .lc_pat_i   (st_lc_pat),
        .busy_o     (busy),
        .done_o     (done),
        .we_o       (we),
        .addr_o     (addr),
        .wdata_o    (wdata)
    );

    assign bp_we    = we;
    assign lc_we    = we;
    assign bp_addr  = addr;
    assign lc_addr  = addr;
    assign bp_wdata = wdata[0];
    assign lc_wdata = wdata[1];

    // No memory write is issued while the block is idle.
    assert_no_idle_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bp_we && !lc_we));

    // Writes in the cycle after an abort never happen.
    assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !bp_we);

endmodule

// File: tb/test_cm_block_fill.sv
`timescale 1ns/1ps
module test_cm_block_fill;
    localparam int DEPTH = 1024;
    localparam int DW    = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int FRAME = 1250;
    localparam logic [DW-1:0] INIT = 16'h1234;

    logic clk = 0;
    logic rst_n = 0;
    logic reg_wr = 0, reg_sel = 0, frame_sync = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic busy, bp_we, lc_we;
    logic [AW-1:0] bp_addr, lc_addr;
    logic [DW-1:0] bp_wdata, lc_wdata;

    always #5 clk = ~clk;

    cm_block_fill #(.DEPTH(DEPTH), .DATA_W(DW)) i_cm_block_fill (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_sync(frame_sync),
        .busy(busy), .bp_we(bp_we), .bp_addr(bp_addr), .bp_wdata(bp_wdata),
        .lc_we(lc_we), .lc_addr(lc_addr), .lc_wdata(lc_wdata));

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // frame boundary generator
    int fcnt = 0;
    always @(negedge clk) begin
        frame_sync <= (fcnt == FRAME - 1);
        fcnt = (fcnt + 1) % FRAME;
    end

    // memories captured from the ports
    logic [DW-1:0] mem_bp [DEPTH];
    logic [DW-1:0] mem_lc [DEPTH];
    logic [DW-1:0] exp_bp [DEPTH];
    logic [DW-1:0] exp_lc [DEPTH];
    int wr_cnt = 0;
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_bp[i] = INIT; mem_lc[i] = INIT; exp_bp[i] = INIT; exp_lc[i] = INIT;
        end
    end
    always @(negedge clk) begin
        if (rst_n && bp_we) begin mem_bp[bp_addr] = bp_wdata; wr_cnt++; end
        if (rst_n && lc_we) mem_lc[lc_addr] = lc_wdata;
    end

    // behavioural reference: mode 0 idle, 1 waiting for frame, 2 sweeping
    int m_mode = 0, m_addr = 0;
    bit m_allow = 0, m_go = 0;
    logic [2:0] m_bp = 0, m_lc = 0, m_sbp = 0, m_slc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_addr = 0; m_allow = 0; m_go = 0;
            m_bp = 0; m_lc = 0; m_sbp = 0; m_slc = 0;
        end else begin
            automatic int  old_mode = m_mode;
            automatic bit  old_go = m_go;
            automatic bit  old_allow = m_allow;
            automatic bit  kill = 0;
            if (old_mode == 2) begin
                exp_bp[m_addr] = {m_sbp, 13'b0};
                exp_lc[m_addr] = {m_slc, 13'b0};
                if (m_addr == DEPTH - 1) begin m_mode = 0; m_go = 0; end
                else m_addr++;
            end else if (old_mode == 1 && frame_sync) begin
                m_mode = 2; m_addr = 0;
            end
            if (reg_wr && !reg_sel) begin
                m_allow = reg_wdata[0];
                if (!reg_wdata[0]) begin m_go = 0; kill = (old_mode != 0); end
            end
            if (reg_wr && reg_sel) begin
                m_bp = reg_wdata[6:4]; m_lc = reg_wdata[3:1];
                if (!reg_wdata[0]) begin m_go = 0; kill = (old_mode != 0); end
                else if (!old_go && old_allow && old_mode == 0) begin
                    m_go = 1; m_mode = 1; m_sbp = reg_wdata[6:4]; m_slc = reg_wdata[3:1];
                end
            end
            if (kill) m_mode = 0;
        end
    end

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk("R2 busy", busy, m_mode != 0);
            chk("R4 bp_we", bp_we, m_mode == 2);
            chk("R4 lc_we", lc_we, m_mode == 2);
            if (m_mode == 2) begin
                chk("R4 bp_addr", bp_addr, m_addr);
                chk("R4 lc_addr", lc_addr, m_addr);
                chk("R5 bp_wdata", bp_wdata, {m_sbp, 13'b0});
                chk("R6 lc_wdata", lc_wdata, {m_slc, 13'b0});
            end
            chk("R11 rdata", reg_rdata,
                reg_sel ? {9'b0, m_bp, m_lc, m_go} : {15'b0, m_allow});
        end
    end

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic sel, input logic [15:0] exp, input string req);
        @(negedge clk);
        reg_sel = sel;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    function automatic logic [15:0] fw(input int bp, input int lc, input int go);
        return 16'((bp << 4) | (lc << 1) | go);
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 3 * FRAME && busy; i++) @(negedge clk);
    endtask

    task automatic wait_write();
        for (int i = 0; i < 3 * FRAME && !bp_we; i++) @(negedge clk);
    endtask

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mem_bp[i] !== exp_bp[i]) d++;
            if (mem_lc[i] !== exp_lc[i]) d++;
        end
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_up();
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, 16'h0, "R1 ctrl");
        rd(1, 16'h0, "R1 fill");
        chk("R1 busy", busy, 0);
        chk("R1 we", bp_we | lc_we, 0);

        // R3 start without permission
        wr(1, fw(5, 2, 1));
        rd(1, fw(5, 2, 0), "R3 go stays low");
        repeat (FRAME + 20) @(negedge clk);
        chk("R3 busy", busy, 0);
        chk("R3 writes", wr_cnt, 0);

        // R2/R4/R5/R6/R7 full fill
        wr(0, 16'h1);
        rd(0, 16'h1, "R11 ctrl allow");
        wr(1, fw(5, 2, 1));
        chk("R2 busy after start", busy, 1);
        rd(1, fw(5, 2, 1), "R2 go reads 1");
        base = wr_cnt;
        wait_idle();
        @(negedge clk);
        chk("R7 busy low", busy, 0);
        rd(1, fw(5, 2, 0), "R7 go self-clears");
        chk("R4 write count", wr_cnt - base, DEPTH);
        chk("R5 bp first", mem_bp[0], 16'hA000);
        chk("R5 bp last", mem_bp[DEPTH-1], 16'hA000);
        chk("R6 lc last", mem_lc[DEPTH-1], 16'h4000);
        chk("R5 R6 contents", mem_diff(), 0);

        // R10 rewrites while busy are ignored by the sweep
        wr(1, fw(3, 6, 1));
        repeat (3) @(negedge clk);
        wr(1, fw(7, 7, 1));
        wait_write();
        wr(1, fw(7, 7, 1));
        wait_idle();
        @(negedge clk);
        chk("R10 bp pattern", mem_bp[DEPTH/2], 16'h6000);
        chk("R10 lc pattern", mem_lc[DEPTH/2], 16'hC000);
        chk("R10 contents", mem_diff(), 0);
        rd(1, fw(7, 7, 0), "R11 pattern readback");

        // R8 abort by start bit mid-sweep
        wr(1, fw(1, 4, 1));
        wait_write();
        repeat (100) @(negedge clk);
        wr(1, fw(1, 4, 0));
        chk("R8 busy", busy, 0);
        base = wr_cnt;
        repeat (FRAME + 20) @(negedge clk);
        chk("R8 no further writes", wr_cnt, base);
        chk("R8 early kept", mem_bp[0], 16'h2000);
        chk("R8 tail untouched", mem_bp[DEPTH-1], 16'h6000);
        chk("R8 contents", mem_diff(), 0);
        rd(1, fw(1, 4, 0), "R8 go low");

        // R9 abort by permission bit mid-sweep
        wr(1, fw(2, 1, 1));
        wait_write();
        repeat (50) @(negedge clk);
        wr(0, 16'h0);
        chk("R9 busy", busy, 0);
        rd(1, fw(2, 1, 0), "R9 go cleared");
        base = wr_cnt;
        repeat (FRAME + 20) @(negedge clk);
        chk("R9 no further writes", wr_cnt, base);
        chk("R9 contents", mem_diff(), 0);

        // R8 abort while waiting for the frame
        wr(0, 16'h1);
        wait (frame_sync == 1);
        @(negedge clk);
        wr(1, fw(6, 5, 1));
        wr(1, fw(6, 5, 0));
        base = wr_cnt;
        repeat (FRAME + 20) @(negedge clk);
        chk("R8 armed abort writes", wr_cnt, base);
        chk("R8 armed abort busy", busy, 0);

        // R4 fresh fill after aborts
        wr(1, fw(4, 3, 1));
        wait_idle();
        @(negedge clk);
        chk("R4 R5 R6 final contents", mem_diff(), 0);
        chk("R6 lc final", mem_lc[7], 16'h6000);
        finish_up();
    end
endmodule